// File: doc/BRIEF.md
# Cache ECC Error Injection Controller

A small control bank that corrupts cache tag or data reads on purpose, so that the error-detection and recovery paths around a cache can be exercised. Software reaches it through a simple register read/write port inside a 128-byte window. It programs three 64-bit registers: a control word, a delay counter and a flip mask.

Once the control word's enable bit is set, the controller becomes armed. This happens at once, or after the delay counter has counted down to zero. The controller then waits for a real cache access that matches the selected component (tag or data) and an enabled bank. On that access it drives the flip mask toward the ECC path, where the mask is XORed into the read word, and raises a one-cycle injection pulse. In one-shot mode the enable bit clears itself after the injection. In persist mode the counter reloads the delay value that software last wrote, and the sequence runs again.

The XOR itself, the ECC codec, the cache arrays and the interrupt logic all sit outside this block.

Top module: `ecc_inj_ctrl`

## Requirements
- R1: After reset, the control word, delay counter and mask all read as 0, and no access is corrupted.
- R2: Register offsets within the window are: control at byte 0, delay at byte 8, mask at byte 16. Control bits are: bit 0 enable, bit 1 persist, bit 2 delay-enable, bit 3 target (0 = tag, 1 = data), and bits [7:4] bank-valid (one bit per bank index). Reads from any other offset, and reads or writes whose low three address bits are not zero, return 0 and leave all state unchanged.
- R3: With enable=1 and delay-enable=0, the next qualifying access is corrupted.
- R4: With enable=1 and delay-enable=1, the counter decreases by one per clock until it reaches 0. Injection is possible only at 0. A read of the delay register returns the live count.
- R5: An access qualifies only if it is valid, its target equals the control target bit, and the bank-valid bit for its bank index is set. Any other access is not corrupted and does not consume the arming.
- R6: With persist=0, a successful injection clears the enable bit, so exactly one access is corrupted per arming.
- R7: With persist=1, a successful injection reloads the counter with the last value written to the delay register, and the block injects again once that count has expired.
- R8: During an injection, the output mask equals the mask register for a data target, and equals the mask register ANDed with the low TAG_W bits for a tag target. The output mask is 0 in every other cycle.
- R9: The injection pulse is high for exactly the cycle of the corrupted access, and it reports the target that was corrupted.
- R10: An expired countdown does not inject on its own. The block stays armed until a qualifying access arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when 1, read when 0 |
| reg_addr_i | input | 7 | Byte offset within the window |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| acc_valid_i | input | 1 | A cache access happens this cycle |
| acc_tgt_i | input | 1 | Access component: 0 tag, 1 data |
| acc_bank_i | input | 2 | Bank index of the access |
| inj_o | output | 1 | Injection pulse |
| inj_tgt_o | output | 1 | Target selected for injection |
| flip_mask_o | output | 64 | XOR mask for the read word |

## Verification
Accesses are driven in four kinds of pattern. Immediate arming shows that enable alone is enough. A countdown sweep, with accesses in every cycle, places the first corruption exactly at zero. Accesses with the wrong target, the wrong bank, or the valid bit low separate qualification from arming. An idle wait after expiry shows that injection waits for traffic. One-shot and persist runs are told apart by what the next access does after a hit and by reading back the counter. A full-ones mask shows the tag-width truncation against the data path.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int unsigned BANKS   = 4;
  localparam int unsigned BANK_IW = $clog2(BANKS);

  // control word, LSB first: en, pst, dly_en, tgt, bank[BANKS-1:0]
  typedef struct packed {
    logic [BANKS-1:0] bank;
    logic             tgt;
    logic             dly_en;
    logic             pst;
    logic             en;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              fire_i,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              wr_dly_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WIDX_W = ADDR_W - 3;
  localparam logic [WIDX_W-1:0] IDX_CTL = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] IDX_DLY = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] IDX_MSK = WIDX_W'(2);

  logic [WIDX_W-1:0] widx;
  logic aligned, wr_ctl, wr_msk;
  ctl_t ctl_q;
  logic [DATA_W-1:0] mask_q;

  assign widx     = addr_i[ADDR_W-1:3];
  assign aligned  = (addr_i[2:0] == 3'b000);
  assign wr_ctl   = req_i && we_i && aligned && (widx == IDX_CTL);
  assign wr_dly_o = req_i && we_i && aligned && (widx == IDX_DLY);
  assign wr_msk   = req_i && we_i && aligned && (widx == IDX_MSK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctl)                      ctl_q    <= ctl_t'(wdata_i[CTL_W-1:0]);
      else if (fire_i && !ctl_q.pst)   ctl_q.en <= 1'b0;  // one-shot self-clear
      if (wr_msk)                      mask_q   <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (widx)
        IDX_CTL: rdata_o[CTL_W-1:0] = ctl_q;
        IDX_DLY: rdata_o = cnt_i;
        IDX_MSK: rdata_o = mask_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign ctl_o  = ctl_q;
  assign mask_o = mask_q;

  assert_oneshot_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !ctl_q.pst && !wr_ctl) |=> !ctl_q.en);
  assert_persist_keeps_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && ctl_q.pst && !wr_ctl) |=> ctl_q.en);
endmodule

// File: rtl/ecc_inj_delay.sv
module ecc_inj_delay #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             run_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
      rel_q <= ld_val_i;
    end else if (reload_i) begin
      cnt_q <= rel_q;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !zero_o && !ld_i && !reload_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
  assert_reload_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !ld_i) |=> (cnt_o == $past(rel_q)));
endmodule

// File: rtl/ecc_inj_fire.sv
module ecc_inj_fire
  import ecc_inj_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 40
) (
  input  logic               en_i,
  input  logic               dly_en_i,
  input  logic               tgt_i,
  input  logic [BANKS-1:0]   bank_i,
  input  logic               zero_i,
  input  logic               acc_valid_i,
  input  logic               acc_tgt_i,
  input  logic [BANK_IW-1:0] acc_bank_i,
  input  logic [DATA_W-1:0]  mask_i,
  output logic               fire_o,
  output logic [DATA_W-1:0]  flip_o
);
  logic armed;
  logic [DATA_W-1:0] tag_keep;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) tag_keep[i] = (i < TAG_W);
  end

  assign armed  = en_i && (!dly_en_i || zero_i);
  assign fire_o = armed && acc_valid_i && (acc_tgt_i == tgt_i) && bank_i[acc_bank_i];
  assign flip_o = !fire_o ? '0 : (tgt_i ? mask_i : (mask_i & tag_keep));
endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 40,
  parameter int unsigned ADDR_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               acc_valid_i,
  input  logic               acc_tgt_i,
  input  logic [BANK_IW-1:0] acc_bank_i,
  output logic               inj_o,
  output logic               inj_tgt_o,
  output logic [DATA_W-1:0]  flip_mask_o
);
  ctl_t ctl;
  logic [DATA_W-1:0] mask, cnt;
  logic wr_dly, zero, fire;

  ecc_inj_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt), .fire_i(fire), .ctl_o(ctl), .mask_o(mask),
    .wr_dly_o(wr_dly), .rdata_o(reg_rdata_o)
  );

  ecc_inj_delay #(.CNT_W(DATA_W)) u_delay (
    .clk_i, .rst_ni,
    .ld_i(wr_dly), .ld_val_i(reg_wdata_i),
    .run_i(ctl.en && ctl.dly_en), .reload_i(fire && ctl.pst),
    .cnt_o(cnt), .zero_o(zero)
  );

  ecc_inj_fire #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_fire (
    .en_i(ctl.en), .dly_en_i(ctl.dly_en), .tgt_i(ctl.tgt), .bank_i(ctl.bank),
    .zero_i(zero), .acc_valid_i, .acc_tgt_i, .acc_bank_i,
    .mask_i(mask), .fire_o(fire), .flip_o(flip_mask_o)
  );

  assign inj_o     = fire;
  assign inj_tgt_o = ctl.tgt;

  assert_fire_needs_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |-> acc_valid_i);
  assert_target_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |-> (inj_tgt_o == acc_tgt_i));
  assert_idle_mask_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (flip_mask_o == '0));

  generate
    if (TAG_W < DATA_W) begin : g_tag_chk
      assert_tag_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inj_o && !inj_tgt_o) |-> (flip_mask_o[DATA_W-1:TAG_W] == '0));
    end
  endgenerate
endmodule

// File: tb/ecc_inj_ctrl_tb.sv
module ecc_inj_ctrl_tb;
  localparam int DATA_W = 64;
  localparam logic [63:0] TAGK = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_ni = 0;
  logic reg_req = 0, reg_we = 0;
  logic [6:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic acc_valid = 0, acc_tgt = 0;
  logic [1:0] acc_bank = '0;
  logic inj, inj_tgt;
  logic [63:0] flip;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [65:0] exp_q[$];
  bit          kind_q[$];   // 1 = register read, 0 = access
  string       req_q[$];
  event        sample_ev;

  always #4 clk = ~clk;

  ecc_inj_ctrl u_dut (
    .clk_i(clk), .rst_ni, .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .acc_valid_i(acc_valid), .acc_tgt_i(acc_tgt), .acc_bank_i(acc_bank),
    .inj_o(inj), .inj_tgt_o(inj_tgt), .flip_mask_o(flip)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sample_ev);
      #1;
      begin
        logic [65:0] e, a;
        bit k;
        string r;
        e = exp_q.pop_front(); k = kind_q.pop_front(); r = req_q.pop_front();
        a = k ? {2'b00, reg_rdata} : {inj, inj & inj_tgt, flip};
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", r, a, e);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [63:0] e, input string r);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    exp_q.push_back({2'b00, e}); kind_q.push_back(1); req_q.push_back(r);
    -> sample_ev;
    @(posedge clk); #1;
    reg_req = 0;
  endtask

  task automatic acc(input logic v, input logic t, input logic [1:0] b,
                     input logic ei, input logic [63:0] em, input string r);
    @(negedge clk);
    acc_valid = v; acc_tgt = t; acc_bank = b;
    exp_q.push_back({ei, ei & t, em}); kind_q.push_back(0); req_q.push_back(r);
    -> sample_ev;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    rd(7'd0,  64'h0, "R1 ctl reset");
    rd(7'd8,  64'h0, "R1 delay reset");
    rd(7'd16, 64'h0, "R1 mask reset");
    acc(1, 1, 2'd0, 0, 64'h0, "R1 no injection after reset");

    // R2 map, invalid and misaligned offsets
    wr(7'd16, 64'hA5A5_0000_1234_00FF);
    rd(7'd16, 64'hA5A5_0000_1234_00FF, "R2 mask readback");
    wr(7'd24, 64'hDEAD_BEEF);
    rd(7'd24, 64'h0, "R2 unmapped offset reads zero");
    wr(7'd17, 64'h1);
    rd(7'd16, 64'hA5A5_0000_1234_00FF, "R2 misaligned write ignored");
    rd(7'd0,  64'h0, "R2 ctl untouched");

    // R3 immediate, data, bank0; R6 one-shot
    wr(7'd0, 64'h19);
    acc(1, 1, 2'd0, 1, 64'hA5A5_0000_1234_00FF, "R3 immediate inject data");
    acc(1, 1, 2'd0, 0, 64'h0, "R6 second access clean");
    rd(7'd0, 64'h18, "R6 enable self-cleared");

    // R5 qualification: data, bank1
    wr(7'd0, 64'h29);
    acc(1, 0, 2'd1, 0, 64'h0, "R5 wrong target");
    acc(1, 1, 2'd0, 0, 64'h0, "R5 bank not enabled");
    acc(0, 1, 2'd1, 0, 64'h0, "R5 access not valid");
    acc(1, 1, 2'd1, 1, 64'hA5A5_0000_1234_00FF, "R5 qualifying access fires");

    // R8 tag truncation, R9 target reported
    wr(7'd16, ONES);
    wr(7'd0, 64'h41);
    acc(1, 0, 2'd2, 1, TAGK, "R8 R9 tag mask truncated");
    acc(1, 0, 2'd2, 0, 64'h0, "R9 single pulse");

    // R4 countdown, D=6
    wr(7'd8, 64'd6);
    wr(7'd0, 64'h1D);
    rd(7'd8, 64'd6, "R4 live count k0");
    rd(7'd8, 64'd5, "R4 live count k1");
    acc(1, 1, 2'd0, 0, 64'h0, "R4 count 4 no inject");
    acc(1, 1, 2'd0, 0, 64'h0, "R4 count 3 no inject");
    acc(1, 1, 2'd0, 0, 64'h0, "R4 count 2 no inject");
    acc(1, 1, 2'd0, 0, 64'h0, "R4 count 1 no inject");
    acc(1, 1, 2'd0, 1, ONES, "R4 inject at zero");
    rd(7'd0, 64'h1C, "R6 cleared after delayed inject");

    // R7 persist, D=2
    wr(7'd8, 64'd2);
    wr(7'd0, 64'h1F);
    acc(1, 1, 2'd0, 0, 64'h0, "R7 k0");
    acc(1, 1, 2'd0, 0, 64'h0, "R7 k1");
    acc(1, 1, 2'd0, 1, ONES, "R7 first inject");
    acc(1, 1, 2'd0, 0, 64'h0, "R7 reloaded k0");
    acc(1, 1, 2'd0, 0, 64'h0, "R7 reloaded k1");
    acc(1, 1, 2'd0, 1, ONES, "R7 second inject");
    rd(7'd8, 64'd2, "R7 counter reloaded");
    rd(7'd0, 64'h1F, "R7 enable kept");
    wr(7'd0, 64'h0);

    // R10 expired countdown waits for access
    wr(7'd8, 64'd2);
    wr(7'd0, 64'h25);
    idle(4);
    rd(7'd8, 64'd0, "R10 counter expired");
    acc(1, 1, 2'd1, 0, 64'h0, "R10 wrong target still armed");
    acc(1, 0, 2'd1, 1, TAGK, "R10 inject on later access");

    #20;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule